// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block lets a slave device answer the SMBus alert poll. A slave signals that it needs service by pulling its open-drain event line low. The host then reads from the Alert Response Address, which is the 7-bit address 0001100 with the read bit set, giving the byte 0x19 on the wire. The block watches SDA and SCL with the system clock and recognises that byte. It then acknowledges the read and shifts out its own slave address.

Several slaves may be alerting at once. They all share the wired-AND bus, so the block arbitrates bit by bit while it sends its address. If it reads back a 0 where it sent a 1, it stops driving at once. Only a slave that sends the whole byte without losing gets to release its alert. It does so through a one-cycle clear pulse to the logic that owns the event output.

The block answers only when all three of these hold: the event output is in interrupt mode, the event polarity is active-low, and an alert is actually pending. Normal register transfers are handled elsewhere.

Top module: `smb_ara_responder`

## Requirements
- R1: After a START, the block takes 8 bits, MSB first, on the rising edges of SCL. If the byte is 0x19, it pulls SDA low for the whole ninth (acknowledge) clock. It never drives SDA while it is receiving the address byte.
- R2: After the acknowledge, the block sends the byte {0011, A2, A1, A0, 0} MSB first on the next 8 clocks, where A2..A0 are `strap_addr[2:0]`. It sends a bit by pulling SDA low for a 0 and releasing it for a 1.
- R3: The block acknowledges 0x19 only when `evt_irq_mode`=1 (interrupt mode), `evt_active_high`=0 (active-low polarity) and `alert_pending`=1. If any of these fails, it leaves SDA released for the rest of the transfer.
- R4: Suppose the block has released SDA to send a 1, and SDA reads 0 at the rising edge of SCL. The block has then lost arbitration. It leaves SDA released for every remaining bit of the transfer.
- R5: `alert_clear` pulses high for exactly one clock. The pulse comes at the rising edge of SCL of the host's acknowledge bit after a reply byte that the block sent in full without losing. It never pulses after a lost arbitration or an unanswered poll.
- R6: After losing arbitration, the block keeps quiet until the next STOP or START. It answers a later alert poll normally.
- R7: The block changes its SDA drive only while SCL is low, and it samples SDA only on rising edges of SCL.
- R8: A START, including a repeated START in the middle of a byte, restarts address reception from the first bit.
- R9: After reset, `sda_pull` and `alert_clear` are both 0.
- R10: Any other address byte, such as 0x18 (a write to the alert address) or 0x1B, is not acknowledged. In that case SDA stays released until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin (wired-AND level) |
| strap_addr | input | 3 | Address strap pins A2..A0 |
| evt_irq_mode | input | 1 | 1 = event output in interrupt mode |
| evt_active_high | input | 1 | Event polarity, 0 = active-low |
| alert_pending | input | 1 | An alert is currently raised |
| sda_pull | output | 1 | 1 = pull SDA low |
| alert_clear | output | 1 | One-cycle request to release the event output |

## Verification
The bench places a second alerting slave on the wired-AND line with a lower or higher address. It then checks three things: the read-back byte equals the lower address, a loser never pulses `alert_clear`, and a winner does so exactly once. A design that kept driving after losing would corrupt the byte the host sees, and one that cleared on any completed byte would drop an alert it never delivered. The bench also turns off each of the three participation conditions in turn and sends non-poll addresses. A design that gated wrongly would acknowledge, which shows up as a 0 on the ninth bit. A repeated START partway through a byte checks that a design does not carry the bit count over. The bench also checks that SDA drive never moves while SCL is high, which would create false START or STOP conditions on the bus.

// File: rtl/smb_ara_pkg.sv
package smb_ara_pkg;

    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS);

    localparam logic [6:0] POLL_ADDR7   = 7'b0001100;
    localparam logic [7:0] POLL_RD_BYTE = {POLL_ADDR7, 1'b1};
    localparam logic [3:0] REPLY_HI     = 4'b0011;

    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for START
        ST_ADDR,      // shifting in address byte
        ST_ACK_WAIT,  // matched, waiting for SCL low to pull ack
        ST_ACK_HOLD,  // holding ack through ninth clock
        ST_SEND,      // shifting out reply byte with arbitration
        ST_HOST_REL,  // release SDA for host ack/nack bit
        ST_HOST_ACK,  // wait for host ack/nack clock
        ST_PARK       // silent until STOP or START
    } ara_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic [BYTE_BITS-1:0] reply_byte(input logic [2:0] strap);
        return {REPLY_HI, strap, 1'b0};
    endfunction

    function automatic logic may_answer(input logic irq_mode, input logic act_high,
                                        input logic pending);
        return irq_mode & ~act_high & pending;
    endfunction

endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon
    import smb_ara_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sh, sda_sh;
    logic         scl_prev, sda_prev;
    logic         scl_s, sda_s;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_in;
                    sda_sh <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[TOP-1:0], scl_in};
                    sda_sh <= {sda_sh[TOP-1:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_s = scl_sh[TOP];
    assign sda_s = sda_sh[TOP];

    always_comb begin
        evt.scl      = scl_s;
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_prev;
        evt.scl_fall = ~scl_s & scl_prev;
        evt.start    = scl_s & scl_prev & ~sda_s & sda_prev;
        evt.stop     = scl_s & scl_prev & sda_s & ~sda_prev;
    end

endmodule

// File: rtl/smb_ara_fsm.sv
module smb_ara_fsm
    import smb_ara_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  bus_evt_t             evt,
    input  logic [BYTE_BITS-1:0] reply,
    input  logic                 allowed,
    output logic                 sda_pull,
    output logic                 alert_clear
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS - 1);

    ara_state_e           st;
    logic [CNT_W-1:0]     cnt;
    logic [BYTE_BITS-1:0] shin;
    logic [BYTE_BITS-1:0] shin_next;
    logic                 pull, clr;

    assign shin_next = {shin[BYTE_BITS-2:0], evt.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            shin <= '0;
            pull <= 1'b0;
            clr  <= 1'b0;
        end else begin
            clr <= 1'b0;
            if (evt.start) begin
                st   <= ST_ADDR;
                cnt  <= '0;
                pull <= 1'b0;
            end else if (evt.stop) begin
                st   <= ST_IDLE;
                pull <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR: if (evt.scl_rise) begin
                        shin <= shin_next;
                        cnt  <= cnt + 1'b1;
                        if (cnt == LAST)
                            st <= (shin_next == POLL_RD_BYTE && allowed) ? ST_ACK_WAIT : ST_PARK;
                    end
                    ST_ACK_WAIT: if (evt.scl_fall) begin
                        pull <= 1'b1;
                        st   <= ST_ACK_HOLD;
                    end
                    ST_ACK_HOLD: if (evt.scl_fall) begin
                        pull <= ~reply[LAST];
                        cnt  <= '0;
                        st   <= ST_SEND;
                    end
                    ST_SEND: begin
                        if (evt.scl_rise) begin
                            if (!pull && !evt.sda) begin
                                st <= ST_PARK;          // arbitration lost
                            end else begin
                                cnt <= cnt + 1'b1;
                                if (cnt == LAST) st <= ST_HOST_REL;
                            end
                        end else if (evt.scl_fall) begin
                            pull <= ~reply[LAST - cnt];
                        end
                    end
                    ST_HOST_REL: if (evt.scl_fall) begin
                        pull <= 1'b0;
                        st   <= ST_HOST_ACK;
                    end
                    ST_HOST_ACK: if (evt.scl_rise) begin
                        clr <= 1'b1;
                        st  <= ST_PARK;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull    = pull;
    assign alert_clear = clr;

    // R7: drive only moves while SCL is low
    a_r7_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        (pull != $past(pull)) |-> !$past(evt.scl));
    // R5: clear is a single-cycle pulse
    a_r5_clear_single: assert property (@(posedge clk) disable iff (rst)
        clr |=> !clr);
    // R5: clear only follows the host acknowledge clock of a full reply
    a_r5_clear_after_reply: assert property (@(posedge clk) disable iff (rst)
        clr |-> ($past(st) == ST_HOST_ACK));
    // R1: silent while the address byte is shifting in
    a_r1_quiet_in_addr: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ADDR) |-> !pull);
    // R4, R10: parked or idle means SDA released
    a_r4_park_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PARK || st == ST_IDLE) |-> !pull);
    // R3: acknowledge path entered only when participation was allowed
    a_r3_ack_needs_permission: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK_WAIT && $past(st) == ST_ADDR) |-> $past(allowed));

endmodule

// File: rtl/smb_ara_responder.sv
module smb_ara_responder
    import smb_ara_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] strap_addr,
    input  logic       evt_irq_mode,
    input  logic       evt_active_high,
    input  logic       alert_pending,
    output logic       sda_pull,
    output logic       alert_clear
);
    bus_evt_t             evt;
    logic [BYTE_BITS-1:0] reply;
    logic                 allowed;

    assign reply   = reply_byte(strap_addr);
    assign allowed = may_answer(evt_irq_mode, evt_active_high, alert_pending);

    smb_line_mon #(.SYNC_STAGES(SYNC_STAGES)) i_mon (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    smb_ara_fsm i_fsm (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .reply       (reply),
        .allowed     (allowed),
        .sda_pull    (sda_pull),
        .alert_clear (alert_clear)
    );

endmodule

// File: tb/test_smb_ara_responder.sv
module test_smb_ara_responder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       host_sda = 1'b1;
    logic       rival_pull = 1'b0;
    logic [2:0] strap = 3'b000;
    logic       irq_mode = 1'b1;
    logic       act_high = 1'b0;
    logic       pending = 1'b1;
    logic       dut_pull, dut_clr;
    logic       sda_bus;

    int total = 0;
    int bad = 0;
    int clr_cnt = 0;
    int hi_moves = 0;
    logic prev_scl = 1'b1;
    logic prev_pull = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    assign sda_bus = host_sda & ~dut_pull & ~rival_pull;

    smb_ara_responder i_smb_ara_responder (
        .clk             (clk),
        .rst             (rst),
        .scl_in          (scl),
        .sda_in          (sda_bus),
        .strap_addr      (strap),
        .evt_irq_mode    (irq_mode),
        .evt_active_high (act_high),
        .alert_pending   (pending),
        .sda_pull        (dut_pull),
        .alert_clear     (dut_clr)
    );

    always @(posedge clk) if (dut_clr === 1'b1) clr_cnt++;

    always @(negedge clk) begin
        if (!rst && scl && prev_scl && dut_pull !== prev_pull) hi_moves++;
        prev_scl  = scl;
        prev_pull = dut_pull;
    end

    // {irq_mode, act_high, pending, strap[2:0], rival_en, rival[7:0], e_ack, e_byte[7:0], e_clr}
    localparam int NV = 9;
    localparam logic [24:0] VEC [NV] = '{
        {3'b101, 3'b101, 1'b0, 8'h00, 1'b1, 8'h3A, 1'b1},
        {3'b101, 3'b000, 1'b0, 8'h00, 1'b1, 8'h30, 1'b1},
        {3'b101, 3'b111, 1'b0, 8'h00, 1'b1, 8'h3E, 1'b1},
        {3'b001, 3'b101, 1'b0, 8'h00, 1'b0, 8'hFF, 1'b0},
        {3'b111, 3'b101, 1'b0, 8'h00, 1'b0, 8'hFF, 1'b0},
        {3'b100, 3'b101, 1'b0, 8'h00, 1'b0, 8'hFF, 1'b0},
        {3'b101, 3'b110, 1'b1, 8'h32, 1'b1, 8'h32, 1'b0},
        {3'b101, 3'b010, 1'b1, 8'h38, 1'b1, 8'h34, 1'b1},
        {3'b101, 3'b011, 1'b1, 8'h37, 1'b1, 8'h36, 1'b1}
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        host_sda = 1'b1; rival_pull = 1'b0; tick(8);
        scl = 1'b1; tick(8);
        host_sda = 1'b0; tick(8);
        scl = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; rival_pull = 1'b0; tick(8);
        scl = 1'b1; tick(8);
        host_sda = 1'b1; tick(8);
    endtask

    task automatic bus_bit(input logic hb, input logic rp, output logic seen);
        tick(8);
        host_sda = hb; rival_pull = rp; tick(8);
        scl = 1'b1; tick(6);
        @(negedge clk); seen = sda_bus;
        tick(6);
        scl = 1'b0;
    endtask

    task automatic xact(input logic [7:0] addr, input logic rv_en, input logic [7:0] rv,
                        output logic ack, output logic [7:0] rd);
        logic s;
        logic alive;
        bus_start();
        for (int i = 7; i >= 0; i--) bus_bit(addr[i], 1'b0, s);
        bus_bit(1'b1, 1'b0, s);
        ack = ~s;
        alive = rv_en;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, alive & ~rv[i], s);
            if (alive && rv[i] && !s) alive = 1'b0;
            rd[i] = s;
        end
        bus_bit(1'b1, 1'b0, s);   // host NACK
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] rd;
        int         c0;
        logic       s;

        tick(6);
        check("R9 sda_pull in reset", dut_pull, 1'b0);
        check("R9 alert_clear in reset", dut_clr, 1'b0);
        rst = 1'b0;
        tick(6);
        check("R9 sda_pull after reset", dut_pull, 1'b0);

        // vector table: R1 ack, R2/R4 byte, R3 gating, R5 clear
        for (int v = 0; v < NV; v++) begin
            irq_mode = VEC[v][24]; act_high = VEC[v][23]; pending = VEC[v][22];
            strap = VEC[v][21:19];
            c0 = clr_cnt;
            xact(8'h19, VEC[v][18], VEC[v][17:10], ack, rd);
            check(VEC[v][9] ? "R1 ack of poll" : "R3 no ack when gated", ack, VEC[v][9]);
            check(VEC[v][18] ? "R4 arbitrated byte" : "R2 reply byte", rd, VEC[v][8:1]);
            check("R5 clear pulse count", clr_cnt - c0, VEC[v][0]);
        end

        // R6: lose, then answer a later poll
        irq_mode = 1'b1; act_high = 1'b0; pending = 1'b1; strap = 3'b110;
        c0 = clr_cnt;
        xact(8'h19, 1'b1, 8'h30, ack, rd);
        check("R6 lost byte", rd, 8'h30);
        check("R6 no clear after loss", clr_cnt - c0, 0);
        xact(8'h19, 1'b0, 8'h00, ack, rd);
        check("R6 later ack", ack, 1'b1);
        check("R6 later byte", rd, 8'h3C);
        check("R6 later clear", clr_cnt - c0, 1);

        // R10: other addresses ignored
        strap = 3'b001;
        c0 = clr_cnt;
        xact(8'h18, 1'b0, 8'h00, ack, rd);
        check("R10 write to poll address ack", ack, 1'b0);
        check("R10 write to poll address byte", rd, 8'hFF);
        xact(8'h1B, 1'b0, 8'h00, ack, rd);
        check("R10 other address ack", ack, 1'b0);
        check("R10 other address byte", rd, 8'hFF);
        check("R10 no clear", clr_cnt - c0, 0);

        // R8: repeated start mid-byte
        bus_start();
        bus_bit(1'b0, 1'b0, s); bus_bit(1'b1, 1'b0, s);
        bus_bit(1'b1, 1'b0, s); bus_bit(1'b0, 1'b0, s);
        c0 = clr_cnt;
        xact(8'h19, 1'b0, 8'h00, ack, rd);
        check("R8 ack after repeated start", ack, 1'b1);
        check("R8 byte after repeated start", rd, 8'h32);
        check("R8 clear after repeated start", clr_cnt - c0, 1);

        // R7: no drive change while SCL high
        check("R7 drive moves during SCL high", hi_moves, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule